// File: doc/BRIEF.md
# Battery Switchover and Chip-Enable Gate

This block decides when a supervised system moves its memory supply onto the backup battery, and it keeps the memory chip-enable inactive while the processor is held in reset, so that RAM is not written while power is failing. It takes the reset state from a reset sequencer, a "supply below reset threshold" flag and a "supply below battery" flag from the analog comparators, the active-low chip-enable from the processor, and two raw comparator results: a power-good flag for an auxiliary input and a battery-good flag.

Backup is entered only when the supply is below the reset threshold and also below the battery voltage. The supply-below-battery flag comes from another domain and passes through a two-stage synchronizer first. While backup is active, the power-good and battery-good outputs are held low. The chip-enable path copies the input through one register while reset is released. After reset asserts, the path stays open for a programmable number of cycles, so a write already under way can finish. It then forces the output high and keeps it high until the sequencer releases reset. After a local reset the gate starts closed, so at power-up nothing reaches the memory before the sequencer's timeout ends.

Top module: `pwr_backup_gate`

## Requirements
- R1: `batt_on_o` rises on the clock edge where `vcc_low_i` is sampled 1 and `vcc_lt_batt_i` was sampled 1 two edges earlier. After `vcc_lt_batt_i` rises, with `vcc_low_i` held at 1, this is the third rising edge.
- R2: While `vcc_low_i` is 0, `vcc_lt_batt_i` = 1 for any length of time never sets `batt_on_o`. It does not mask the status flags and it does not close the chip-enable gate.
- R3: `batt_on_o` falls on the first edge at which `vcc_low_i` is sampled 0.
- R4: While the gate is open, `ce_n_o` equals the `ce_n_i` value sampled at the previous edge. Every transition passes.
- R5: `sys_rst_i` (1 = reset asserted) is first sampled high at edge E0. `ce_off_o` rises and `ce_n_o` is forced to 1 at edge E0+DIS_DLY-1. Before that edge the input still passes.
- R6: While `ce_off_o` = 1, `ce_n_o` stays 1 whatever `ce_n_i` does. At the first edge that samples `sys_rst_i` = 0, `ce_off_o` falls and passing resumes.
- R7: If `sys_rst_i` is high for fewer than DIS_DLY consecutive edges, the gate never closes, and the delay count starts again from zero at the next assertion.
- R8: Outside backup, `pf_ok_o` and `bat_ok_o` follow `pf_ok_raw_i` and `bat_ok_raw_i` with one edge of latency. On every edge where backup is entered or held, both are 0.
- R9: While `rst` (synchronous, active high) is 1, the outputs are `batt_on_o` = 0, `ce_off_o` = 1, `ce_n_o` = 1, `pf_ok_o` = 0 and `bat_ok_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of this block |
| sys_rst_i | input | 1 | Reset state from the sequencer, 1 = processor held in reset |
| vcc_low_i | input | 1 | Supply is below the reset threshold |
| vcc_lt_batt_i | input | 1 | Supply is below the battery voltage (asynchronous) |
| ce_n_i | input | 1 | Chip-enable from the processor, active low |
| pf_ok_raw_i | input | 1 | Raw auxiliary power-good comparator result |
| bat_ok_raw_i | input | 1 | Raw battery-good comparator result |
| batt_on_o | output | 1 | 1 = memory supply runs from the battery |
| ce_n_o | output | 1 | Gated chip-enable to the memory, active low |
| ce_off_o | output | 1 | 1 = chip-enable gate closed |
| pf_ok_o | output | 1 | Power-good flag, forced low in backup |
| bat_ok_o | output | 1 | Battery-good flag, forced low in backup |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause. The gated chip-enable and the two status flags are due one edge after their input. The battery flag is due one edge after `vcc_low_i` and three edges after `vcc_lt_batt_i`. The gate closes DIS_DLY-1 edges after the first edge that sees reset, and it opens one edge after reset drops. The bench model advances on the rising edge using the same counts, through a history queue and an integer counter. Outputs are compared at the falling edge, where every registered value is settled. The directed checks count whole falling edges from the one on which the stimulus was applied.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    // Chip-enable gate condition.
    typedef enum logic {
        G_OPEN = 1'b0,
        G_SHUT = 1'b1
    } gate_t;

    // Comparator status carried as one unit.
    typedef struct packed {
        logic pf_ok;
        logic bat_ok;
    } stat_t;

    localparam stat_t STAT_CLEAR = '{pf_ok: 1'b0, bat_ok: 1'b0};

    // Status seen by the system: all clear while on battery.
    function automatic stat_t mask_stat(input stat_t raw, input logic backup);
        stat_t r;
        r.pf_ok  = raw.pf_ok  & ~backup;
        r.bat_ok = raw.bat_ok & ~backup;
        return r;
    endfunction

    // Width of a counter that must hold values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pbg_sync.sv
module pbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= d_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbg_mode.sv
module pbg_mode
    import pbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vcc_low_i,
    input  logic  lt_batt_s_i,
    input  stat_t raw_i,
    output logic  batt_on_o,
    output stat_t stat_o
);
    logic  backup_d;
    logic  batt_q;
    stat_t stat_q;

    // Both conditions together; battery above a healthy supply does nothing.
    assign backup_d = vcc_low_i & lt_batt_s_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            batt_q <= 1'b0;
            stat_q <= STAT_CLEAR;
        end else begin
            batt_q <= backup_d;
            stat_q <= mask_stat(raw_i, backup_d);
        end
    end

    assign batt_on_o = batt_q;
    assign stat_o    = stat_q;
endmodule

// File: rtl/pbg_ce_gate.sv
module pbg_ce_gate
    import pbg_pkg::*;
#(
    parameter int DIS_DLY = 1400
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic ce_n_i,
    output logic ce_n_o,
    output logic shut_o
);
    localparam int            CW   = cnt_w(DIS_DLY);
    localparam logic [CW-1:0] LAST = CW'(DIS_DLY - 1);

    gate_t         st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ce_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!hold_i) begin
            st_d  = G_OPEN;
            cnt_d = '0;
        end else if (st_q == G_OPEN) begin
            if (cnt_q == LAST) begin
                st_d  = G_SHUT;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= G_SHUT;
            cnt_q <= '0;
            ce_q  <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ce_q  <= (st_d == G_SHUT) ? 1'b1 : ce_n_i;
        end
    end

    assign ce_n_o = ce_q;
    assign shut_o = (st_q == G_SHUT);
endmodule

// File: rtl/pwr_backup_gate.sv
module pwr_backup_gate
    import pbg_pkg::*;
#(
    parameter int DIS_DLY     = 1400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_rst_i,
    input  logic vcc_low_i,
    input  logic vcc_lt_batt_i,
    input  logic ce_n_i,
    input  logic pf_ok_raw_i,
    input  logic bat_ok_raw_i,
    output logic batt_on_o,
    output logic ce_n_o,
    output logic ce_off_o,
    output logic pf_ok_o,
    output logic bat_ok_o
);
    logic  lt_batt_s;
    stat_t raw_stat;
    stat_t out_stat;

    assign raw_stat = '{pf_ok: pf_ok_raw_i, bat_ok: bat_ok_raw_i};

    pbg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (vcc_lt_batt_i),
        .q_o (lt_batt_s)
    );

    pbg_mode mode_i (
        .clk         (clk),
        .rst         (rst),
        .vcc_low_i   (vcc_low_i),
        .lt_batt_s_i (lt_batt_s),
        .raw_i       (raw_stat),
        .batt_on_o   (batt_on_o),
        .stat_o      (out_stat)
    );

    pbg_ce_gate #(.DIS_DLY(DIS_DLY)) gate_i (
        .clk    (clk),
        .rst    (rst),
        .hold_i (sys_rst_i),
        .ce_n_i (ce_n_i),
        .ce_n_o (ce_n_o),
        .shut_o (ce_off_o)
    );

    assign pf_ok_o  = out_stat.pf_ok;
    assign bat_ok_o = out_stat.bat_ok;
endmodule

// File: rtl/pwr_backup_gate_chk.sv
module pwr_backup_gate_chk #(
    parameter int DIS_DLY = 1400
) (
    input logic clk,
    input logic rst,
    input logic sys_rst_i,
    input logic vcc_low_i,
    input logic ce_n_i,
    input logic batt_on_o,
    input logic ce_n_o,
    input logic ce_off_o,
    input logic pf_ok_o,
    input logic bat_ok_o
);
    // R1: battery mode only follows a sampled low supply
    p_batt_needs_low_r1: assert property (@(posedge clk) disable iff (rst)
        batt_on_o |-> $past(vcc_low_i));

    // R3: supply back above threshold ends backup at the next edge
    p_batt_exit_r3: assert property (@(posedge clk) disable iff (rst)
        !vcc_low_i |=> !batt_on_o);

    // R4: open gate copies the input with one edge of latency
    p_ce_pass_r4: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_i |=> (ce_n_o == $past(ce_n_i)));

    // R6: closed gate drives inactive high
    p_ce_forced_high_r6: assert property (@(posedge clk) disable iff (rst)
        ce_off_o |-> ce_n_o);

    // R6: closed gate holds while reset stays asserted
    p_ce_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ce_off_o && sys_rst_i) |=> ce_off_o);

    // R6: reset release reopens the gate
    p_ce_release_r6: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_i |=> !ce_off_o);

    // R8: status flags are low whenever on battery
    p_stat_masked_r8: assert property (@(posedge clk) disable iff (rst)
        batt_on_o |-> (!pf_ok_o && !bat_ok_o));

    // R5: gate does not close on the first edge that sees reset
    generate
        if (DIS_DLY > 1) begin : g_delay_chk
            p_no_instant_off_r5: assert property (@(posedge clk) disable iff (rst)
                ($rose(sys_rst_i) && !ce_off_o) |=> !ce_off_o);
        end
    endgenerate
endmodule

bind pwr_backup_gate pwr_backup_gate_chk #(.DIS_DLY(DIS_DLY)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sys_rst_i (sys_rst_i),
    .vcc_low_i (vcc_low_i),
    .ce_n_i    (ce_n_i),
    .batt_on_o (batt_on_o),
    .ce_n_o    (ce_n_o),
    .ce_off_o  (ce_off_o),
    .pf_ok_o   (pf_ok_o),
    .bat_ok_o  (bat_ok_o)
);

// File: tb/pwr_backup_gate_tb_top.sv
module pwr_backup_gate_tb_top;
    localparam int DLY = 1400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_rst = 1'b1;
    logic vcc_low = 1'b0;
    logic lt_batt = 1'b0;
    logic ce_in = 1'b1;
    logic pf_raw = 1'b0;
    logic bok_raw = 1'b0;
    logic batt_on, ce_out, ce_off, pf_ok, bat_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_backup_gate #(.DIS_DLY(DLY)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .sys_rst_i     (sys_rst),
        .vcc_low_i     (vcc_low),
        .vcc_lt_batt_i (lt_batt),
        .ce_n_i        (ce_in),
        .pf_ok_raw_i   (pf_raw),
        .bat_ok_raw_i  (bok_raw),
        .batt_on_o     (batt_on),
        .ce_n_o        (ce_out),
        .ce_off_o      (ce_off),
        .pf_ok_o       (pf_ok),
        .bat_ok_o      (bat_ok)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // Behavioural reference: history queue and a run-length counter.
    bit m_started = 0;
    bit m_batt, m_pf, m_bok, m_off, m_ce;
    int hi_run;
    bit lt_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            lt_hist.delete();
            m_batt = 0; m_pf = 0; m_bok = 0;
            m_off = 1; m_ce = 1; hi_run = 0;
            m_started = 1;
        end else begin
            bit old_lt, bk;
            lt_hist.push_back(lt_batt);
            if (lt_hist.size() > 3) void'(lt_hist.pop_front());
            old_lt = (lt_hist.size() == 3) ? lt_hist[0] : 1'b0;
            bk = vcc_low && old_lt;
            m_batt = bk;
            m_pf  = pf_raw && !bk;
            m_bok = bok_raw && !bk;
            if (!sys_rst) begin
                hi_run = 0; m_off = 0; m_ce = ce_in;
            end else if (m_off) begin
                m_ce = 1;
            end else begin
                hi_run++;
                if (hi_run >= DLY) begin
                    m_off = 1; m_ce = 1; hi_run = 0;
                end else begin
                    m_ce = ce_in;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (m_started && !done) begin
            chk("R1 batt_on", batt_on, m_batt);
            chk("R4 ce_n_o", ce_out, m_ce);
            chk("R5 ce_off", ce_off, m_off);
            chk("R8 pf_ok", pf_ok, m_pf);
            chk("R8 bat_ok", bat_ok, m_bok);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_in   = $urandom_range(0, 1);
            pf_raw  = $urandom_range(0, 1);
            bok_raw = $urandom_range(0, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pf_raw = 1; bok_raw = 1; ce_in = 0;
        @(negedge clk);
        // R9: reset state
        chk("R9 batt_on", batt_on, 1'b0);
        chk("R9 ce_off", ce_off, 1'b1);
        chk("R9 ce_n_o", ce_out, 1'b1);
        chk("R9 pf_ok", pf_ok, 1'b0);
        chk("R9 bat_ok", bat_ok, 1'b0);
        rst = 0;

        // R6: power-up with reset held, gate stays closed
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ce_in = ~ce_in;
            chk("R6 closed at power-up", ce_out, 1'b1);
        end
        sys_rst = 0;
        @(negedge clk);
        chk("R6 reopen", ce_off, 1'b0);
        tick(40);

        // R2: battery above healthy supply
        lt_batt = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pf_raw = 1;
            chk("R2 no switchover", batt_on, 1'b0);
        end
        chk("R2 gate open", ce_off, 1'b0);
        chk("R2 pf unmasked", pf_ok, 1'b1);
        lt_batt = 0;
        tick(5);

        // R7: short reset pulse does not close the gate
        sys_rst = 1;
        tick(5);
        sys_rst = 0;
        tick(2);
        chk("R7 short pulse", ce_off, 1'b0);

        // R5: exact close edge
        @(negedge clk);
        sys_rst = 1;
        tick(DLY - 1);
        chk("R5 still open", ce_off, 1'b0);
        tick(1);
        chk("R5 closed", ce_off, 1'b1);
        chk("R5 forced high", ce_out, 1'b1);
        tick(10);

        // R1, R8, R3: backup entry and exit (reset held)
        @(negedge clk);
        vcc_low = 1; lt_batt = 1;
        pf_raw = 1; bok_raw = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 not yet", batt_on, 1'b0);
        @(negedge clk);
        chk("R1 entered", batt_on, 1'b1);
        chk("R8 pf forced", pf_ok, 1'b0);
        chk("R8 bok forced", bat_ok, 1'b0);
        tick(6);
        vcc_low = 0;
        @(negedge clk);
        chk("R3 exit", batt_on, 1'b0);
        lt_batt = 0;
        sys_rst = 0;
        tick(30);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule